// File: doc/BRIEF.md
# Bus-Mapped Display and Keypad Port

This block sits on a microprocessor bus that runs with a phase-2 clock and serves two jobs: it drives a multiplexed seven-segment LED display, and it lets software read a key matrix one column at a time. Software writes one byte to the display select with an indexed store. The store's data byte becomes the segment pattern. The low address bits of the same store pick which digit (and key column) is driven, on a one-hot active-low output. A read on a second select places the current key-row value on the data bus.

Both display latches are opened only while the display select is active and phase 2 is high. They close when phase 2 falls. The held digit is therefore the address that was valid during phase 2 high, even though the address lines start moving toward the next bus cycle inside the hold window. The digit latch captures on reads as well as on writes. The segment latch captures only on writes. Real tri-state pins are left to the pad ring: the key driver is shown as a data word plus an output-enable.

The bus inputs are sampled by a fast system clock `clk`. While its window is open, each latch is transparent from input to output through combinational logic. Once the window closes, the latch holds the value it registered at the last clock edge inside the window.

Top module: `dispkey_top`

## Requirements
- R1: After reset, every digit output `digitN` is high (8'hFF), `segOut` is 8'h00 and `keyOe` is low.
- R2: The display window is open only when `dispSelN` is low and `phi2` is high. With `dispSelN` high, or with `phi2` low, changes on `addrLo` and `dataIn` have no effect on `digitN` or `segOut`.
- R3: While the display window is open, `digitN` follows `addrLo` with no clock delay. Bit k is low exactly when `addrLo` equals k, and every other bit is high.
- R4: When `phi2` falls, `digitN` keeps the value from the address present at the last clock edge with `phi2` high. Address changes that arrive after `phi2` falls do not alter it.
- R5: The digit latch captures `addrLo` whether `rnw` is 1 (read) or 0 (write).
- R6: `segOut` loads `dataIn` only during an open window with `rnw` = 0. It is transparent within that window and holds afterward. A read on the display select leaves `segOut` unchanged.
- R7: A single write cycle on the display select sets both `segOut` and the active digit.
- R8: `keyOe` is high, and `keyData` equals `keyRowIn`, only when `keySelN` is low, `phi2` is high and `rnw` = 1. At all other times `keyOe` is low and `keyData` is 8'h00.
- R9: Cycles on the key select never change `digitN` or `segOut`. Cycles on the display select never raise `keyOe`.
- R10: At most one bit of `digitN` is low at any time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System sampling clock |
| rstN | input | 1 | Active-low synchronous reset |
| phi2 | input | 1 | Bus phase-2 clock |
| rnw | input | 1 | Bus direction, 1 = read, 0 = write |
| dispSelN | input | 1 | Active-low decoded display select |
| keySelN | input | 1 | Active-low decoded key select |
| addrLo | input | 3 | Address low bits, digit/column number |
| dataIn | input | 8 | Data bus into the block |
| keyRowIn | input | 8 | Key matrix row lines |
| digitN | output | 8 | One-hot active-low digit/column drive |
| segOut | output | 8 | Latched segment pattern |
| keyData | output | 8 | Key-row value for the data bus |
| keyOe | output | 1 | Data bus drive enable for keyData |

## Verification
Stores are made to each of the eight addresses with distinct data. This shows that decoding and segment loading are correct per digit, and that one store sets both. The address is moved in the middle of phase 2 high, and again after phase 2 falls. The first move shows the latch is transparent. The second separates a correct close on the falling edge from a latch that closes late and takes the next cycle's address. Reads on the display select are compared with writes to show that only the digit latch ignores direction. Key-select reads, key-select writes, and display selects with phase 2 low are each mixed with moving address and data, to show that nothing leaks across selects or outside the qualified window.

// File: rtl/dispkey_pkg.sv
package dispkey_pkg;

  // Strobes from control to datapath for one bus sample
  typedef struct packed {
    logic dispOpen;  // display latches transparent
    logic segLoad;   // segment latch takes the data bus
    logic keyDrive;  // key rows go onto the data bus
  } busStrobes_t;

endpackage

// File: rtl/dispkey_ctrl.sv
module dispkey_ctrl
  import dispkey_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        phi2,
  input  logic        rnw,
  input  logic        dispSelN,
  input  logic        keySelN,
  output busStrobes_t strobes
);

  // Qualified latch enable, active low: high unless select active and phi2 high
  logic latchEnN;
  logic dispSel;
  logic keySel;

  assign dispSel  = ~dispSelN;
  assign keySel   = ~keySelN;
  assign latchEnN = ~(dispSel & phi2);

  always_comb begin
    strobes          = '0;
    strobes.dispOpen = ~latchEnN;
    strobes.segLoad  = ~latchEnN & ~rnw;
    strobes.keyDrive = keySel & phi2 & rnw;
  end

  // Segment loading is a subset of the display window
  assert_seg_in_window_R6: assert property (@(posedge clk) disable iff (!rstN)
    strobes.segLoad |-> strobes.dispOpen);

  // Key drive and display window come from different selects; phi2 low shuts both
  assert_phi2_low_quiet_R2: assert property (@(posedge clk) disable iff (!rstN)
    !phi2 |-> !(strobes.dispOpen || strobes.keyDrive));

endmodule

// File: rtl/dispkey_dpath.sv
module dispkey_dpath
  import dispkey_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 8,
  parameter int KEY_W  = 8,
  localparam int NUM_DIGITS = 1 << ADDR_W
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  busStrobes_t           strobes,
  input  logic [ADDR_W-1:0]     addrLo,
  input  logic [DATA_W-1:0]     dataIn,
  input  logic [KEY_W-1:0]      keyRowIn,
  output logic [NUM_DIGITS-1:0] digitN,
  output logic [DATA_W-1:0]     segOut,
  output logic [KEY_W-1:0]      keyData,
  output logic                  keyOe
);

  logic [ADDR_W-1:0] heldAddr;
  logic              heldValid;
  logic [DATA_W-1:0] heldSeg;
  logic              started;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      heldAddr  <= '0;
      heldValid <= 1'b0;
      heldSeg   <= '0;
      started   <= 1'b0;
    end else begin
      started <= 1'b1;
      if (strobes.dispOpen) begin
        heldAddr  <= addrLo;
        heldValid <= 1'b1;
      end
      if (strobes.segLoad) begin
        heldSeg <= dataIn;
      end
    end
  end

  // Transparent path while open, held value otherwise
  logic [ADDR_W-1:0] liveAddr;
  logic              liveValid;

  assign liveAddr  = strobes.dispOpen ? addrLo : heldAddr;
  assign liveValid = strobes.dispOpen | heldValid;

  for (genvar k = 0; k < NUM_DIGITS; k++) begin : g_digit
    assign digitN[k] = ~(liveValid && (liveAddr == ADDR_W'(k)));
  end

  assign segOut  = strobes.segLoad ? dataIn : heldSeg;
  assign keyOe   = strobes.keyDrive;
  assign keyData = strobes.keyDrive ? keyRowIn : '0;

  assert_one_digit_R10: assert property (@(posedge clk) disable iff (!rstN)
    $countones(~digitN) <= 1);

  assert_digit_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    (started && !strobes.dispOpen && $past(!strobes.dispOpen)) |-> $stable(digitN));

  assert_seg_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    (started && !strobes.segLoad && $past(!strobes.segLoad)) |-> $stable(segOut));

  assert_unlatched_dark_R1: assert property (@(posedge clk) disable iff (!rstN)
    (!heldValid && !strobes.dispOpen) |-> (digitN == '1));

  assert_key_quiet_R8: assert property (@(posedge clk) disable iff (!rstN)
    !keyOe |-> (keyData == '0));

endmodule

// File: rtl/dispkey_top.sv
module dispkey_top
  import dispkey_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 8,
  parameter int KEY_W  = 8,
  localparam int NUM_DIGITS = 1 << ADDR_W
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  phi2,
  input  logic                  rnw,
  input  logic                  dispSelN,
  input  logic                  keySelN,
  input  logic [ADDR_W-1:0]     addrLo,
  input  logic [DATA_W-1:0]     dataIn,
  input  logic [KEY_W-1:0]      keyRowIn,
  output logic [NUM_DIGITS-1:0] digitN,
  output logic [DATA_W-1:0]     segOut,
  output logic [KEY_W-1:0]      keyData,
  output logic                  keyOe
);

  busStrobes_t strobes;

  dispkey_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .phi2     (phi2),
    .rnw      (rnw),
    .dispSelN (dispSelN),
    .keySelN  (keySelN),
    .strobes  (strobes)
  );

  dispkey_dpath #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .KEY_W  (KEY_W)
  ) u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .addrLo   (addrLo),
    .dataIn   (dataIn),
    .keyRowIn (keyRowIn),
    .digitN   (digitN),
    .segOut   (segOut),
    .keyData  (keyData),
    .keyOe    (keyOe)
  );

  // Display select never drives the bus
  assert_disp_no_drive_R9: assert property (@(posedge clk) disable iff (!rstN)
    (keySelN && phi2) |-> !keyOe);

endmodule

// File: tb/dispkey_top_tb.sv
module dispkey_top_tb;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       phi2 = 1'b0;
  logic       rnw = 1'b1;
  logic       dispSelN = 1'b1;
  logic       keySelN = 1'b1;
  logic [2:0] addrLo = '0;
  logic [7:0] dataIn = '0;
  logic [7:0] keyRowIn = '0;
  logic [7:0] digitN;
  logic [7:0] segOut;
  logic [7:0] keyData;
  logic       keyOe;

  int checks = 0;
  int failures = 0;
  logic [7:0] expDigit = 8'hFF;
  logic [7:0] expSeg = 8'h00;

  always #4 clk = ~clk;  // 125 MHz

  dispkey_top u_dut (
    .clk(clk), .rstN(rstN), .phi2(phi2), .rnw(rnw),
    .dispSelN(dispSelN), .keySelN(keySelN), .addrLo(addrLo),
    .dataIn(dataIn), .keyRowIn(keyRowIn), .digitN(digitN),
    .segOut(segOut), .keyData(keyData), .keyOe(keyOe)
  );

  function automatic logic [7:0] dec(input logic [2:0] a);
    return ~(8'h01 << a);
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic sample();
    @(posedge clk);
    #2;
  endtask

  task automatic checkDisplay(input string tag);
    check({tag, " digit"}, {24'd0, digitN}, {24'd0, expDigit});
    check({tag, " seg"}, {24'd0, segOut}, {24'd0, expSeg});
  endtask

  // One display-select cycle; address moves inside the hold window after phi2 falls
  task automatic dispCycle(input logic rd, input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    phi2 = 1'b0; rnw = rd; addrLo = a; dataIn = d; dispSelN = 1'b0;
    sample();
    checkDisplay("R2 select with phi2 low");
    @(negedge clk);
    phi2 = 1'b1;
    sample();
    expDigit = dec(a);
    if (!rd) expSeg = d;
    check("R3 transparent digit", {24'd0, digitN}, {24'd0, expDigit});
    check("R7 segment in window", {24'd0, segOut}, {24'd0, expSeg});
    check("R9 no bus drive from display", {31'd0, keyOe}, 32'd0);
    @(negedge clk);
    phi2 = 1'b0;
    sample();
    checkDisplay("R4 after phi2 fall");
    @(negedge clk);
    addrLo = a + 3'd3; dataIn = ~d;
    sample();
    checkDisplay("R4 address moved in hold window");
    @(negedge clk);
    dispSelN = 1'b1; rnw = 1'b1;
    sample();
    checkDisplay("R4 select released");
  endtask

  task automatic t_reset();
    check("R1 reset digits", {24'd0, digitN}, 32'hFF);
    check("R1 reset segments", {24'd0, segOut}, 32'h00);
    check("R1 reset keyOe", {31'd0, keyOe}, 32'd0);
  endtask

  task automatic t_allStores();
    for (int i = 0; i < 8; i++) begin
      dispCycle(1'b0, 3'(i), 8'(8'h11 * (i + 1)));
      check("R10 single digit low", 32'($countones(~digitN)), 32'd1);
    end
  endtask

  task automatic t_midWindowMove();
    @(negedge clk);
    rnw = 1'b0; addrLo = 3'd1; dataIn = 8'h3C; dispSelN = 1'b0; phi2 = 1'b1;
    sample();
    check("R3 follows first address", {24'd0, digitN}, {24'd0, dec(3'd1)});
    @(negedge clk);
    addrLo = 3'd6; dataIn = 8'hC3;
    sample();
    check("R3 follows moved address", {24'd0, digitN}, {24'd0, dec(3'd6)});
    check("R6 segment transparent", {24'd0, segOut}, 32'hC3);
    @(negedge clk);
    phi2 = 1'b0;
    @(negedge clk);
    addrLo = 3'd2; dataIn = 8'h00; dispSelN = 1'b1; rnw = 1'b1;
    expDigit = dec(3'd6); expSeg = 8'hC3;
    sample();
    checkDisplay("R4 holds last in-window address");
  endtask

  task automatic t_readOnDisplay();
    dispCycle(1'b1, 3'd5, 8'hA5);
    check("R5 digit taken on read", {24'd0, digitN}, {24'd0, dec(3'd5)});
    check("R6 segment kept on read", {24'd0, segOut}, 32'hC3);
  endtask

  task automatic t_noSelect();
    @(negedge clk);
    rnw = 1'b0; dispSelN = 1'b1; addrLo = 3'd0; dataIn = 8'h99; phi2 = 1'b1;
    sample();
    @(negedge clk);
    addrLo = 3'd7;
    sample();
    checkDisplay("R2 no select with phi2 high");
    @(negedge clk);
    phi2 = 1'b0; rnw = 1'b1;
    sample();
  endtask

  task automatic t_keys();
    keyRowIn = 8'h5A;
    @(negedge clk);
    keySelN = 1'b0; rnw = 1'b1; addrLo = 3'd3; dataIn = 8'hEE;
    sample();
    check("R8 key idle with phi2 low", {23'd0, keyOe, keyData}, 32'h000);
    @(negedge clk);
    phi2 = 1'b1;
    sample();
    check("R8 key read drives rows", {23'd0, keyOe, keyData}, 32'h15A);
    @(negedge clk);
    keyRowIn = 8'hA7;
    sample();
    check("R8 key read tracks rows", {23'd0, keyOe, keyData}, 32'h1A7);
    checkDisplay("R9 key read leaves display");
    @(negedge clk);
    rnw = 1'b0;
    sample();
    check("R8 key write no drive", {23'd0, keyOe, keyData}, 32'h000);
    checkDisplay("R9 key write leaves display");
    @(negedge clk);
    phi2 = 1'b0; keySelN = 1'b1; rnw = 1'b1;
    sample();
    check("R8 key deselected", {23'd0, keyOe, keyData}, 32'h000);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2;
    t_reset();
    @(negedge clk);
    rstN = 1'b1;
    sample();
    t_reset();
    t_allStores();
    t_midWindowMove();
    t_readOnDisplay();
    t_noSelect();
    t_keys();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule